// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block walks one DMA channel through a buffer laid out as rows of elements. It holds the current address, the remaining elements in the current row (X count) and the remaining rows (Y count). Each element is handed to an external data mover through a valid/ready request. The request carries the address, the transfer direction and the element size. The mover answers with the number of bytes it moved, in the same cycle that it accepts the request.

After the last element of a row, the block raises a per-row interrupt pulse. In two-dimensional mode it then jumps to the start of the next row. When the final row is done, one of two things happens. In stop mode the channel halts and reports completion. In chained mode it asks an external fetcher for the next descriptor, which the fetcher presents on the configuration inputs when it acknowledges.

A zero-byte answer is a stall, and the element is retried after a fixed gap. Any other answer that does not match the element size is an error, and the error halts the channel.

Top module: `dma2d_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `irq`, `mv_valid` and `desc_req` are all low.
- R2: A `go` pulse while idle, with an aligned start address, does the following: it loads `mv_addr` with the start address and `cur_x`/`cur_y` with the configured counts, sets `busy`, and clears `done` and `err`.
- R3: A configured count of zero is loaded as the largest count, 2^CW-1.
- R4: On `go`, the start address must be a multiple of the element size, or `err` is set and `busy` stays low. The element-size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
- R5: While `mv_valid` is high and `mv_ready` is low, `mv_valid` and `mv_addr` hold. When a request is accepted with `mv_bytes` equal to the element size, an element within a row advances the address by the signed X modify and decrements `cur_x`.
- R6: In 2D mode, the last element of a row when `cur_y` > 1 does the following: the next address is that element's address plus the signed Y modify, `cur_x` reloads, and `cur_y` decrements.
- R7: With interrupt enable set, `irq` pulses for exactly one cycle after the last element of every row is accepted. With it clear, `irq` stays low.
- R8: In stop mode, completing the final row clears `busy`, sets `done` and issues no further request.
- R9: In chained mode, completing the final row raises `desc_req`, keeps `busy` high and issues no request. `desc_ack` then reloads from the configuration inputs and resumes.
- R10: An accepted request with `mv_bytes` = 0 leaves the address and counts unchanged. `mv_valid` then stays low for exactly RETRY_GAP cycles before the element is reissued.
- R11: An accepted request with a nonzero `mv_bytes` other than the element size sets `err`, clears `busy`, does not count the element, and issues no further request.
- R12: No new request is issued while `en` is low. Dropping `en` lets the request in flight complete, and then stepping stops until `en` returns.
- R13: While busy, `go` and changes to the configuration inputs have no effect on the address, the counts or the number of elements moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Start pulse, taken only when idle |
| en | input | 1 | Enables issuing of element requests |
| cfg_start | input | AW | Start address |
| cfg_xcnt | input | CW | Elements per row (0 = maximum) |
| cfg_xmod | input | MW | Signed address step between elements |
| cfg_ycnt | input | CW | Row count (0 = maximum) |
| cfg_ymod | input | MW | Signed step from a row's last element to the next row |
| cfg_2d | input | 1 | Two-dimensional mode |
| cfg_stop | input | 1 | Stop mode (1) or chained mode (0) |
| cfg_wr | input | 1 | Direction: 1 writes memory, 0 reads memory |
| cfg_esize | input | 2 | Element-size code |
| cfg_irq_en | input | 1 | Per-row interrupt enable |
| desc_req | output | 1 | Request for the next descriptor |
| desc_ack | input | 1 | Next descriptor present on the cfg inputs |
| mv_valid | output | 1 | Element request valid |
| mv_ready | input | 1 | Mover accepts the request |
| mv_addr | output | AW | Element address |
| mv_wr | output | 1 | Element direction |
| mv_esize | output | 2 | Element-size code |
| mv_bytes | input | 4 | Bytes moved, sampled on acceptance |
| busy | output | 1 | Channel running |
| done | output | 1 | Stop-mode completion |
| err | output | 1 | Alignment or byte-count error |
| irq | output | 1 | Per-row interrupt pulse |
| cur_x | output | CW | Remaining elements in the row |
| cur_y | output | CW | Remaining rows |

## Verification
The assertions watch the following on every cycle:
- the request holds while back-pressured;
- a stall freezes the address and counts;
- an element decrements `cur_x`;
- a row step adds the Y modify;
- `irq` follows only a row's last element;
- an error or completion drops `busy`;
- no request starts without `en`.

Other properties are visible only through the bench's scenarios:
- the full address sequence over every size, sign and shape of buffer;
- the exact retry gap;
- the per-row interrupt count;
- descriptor chaining;
- the treatment of zero counts;
- the fact that `go` and configuration changes are ignored mid-run.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ARM  = 3'd1,
    S_REQ  = 3'd2,
    S_WAIT = 3'd3,
    S_DESC = 3'd4
  } seq_state_e;

  // Element-size code to bytes: 0 -> 1, 1 -> 2, 2/3 -> 4
  function automatic logic [3:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_retry.sv
module dma2d_retry #(
  parameter int GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int TW = $clog2(GAP + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= TW'(GAP - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dma2d_datapath.sv
module dma2d_datapath #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic                 row_step,
  input  logic [AW-1:0]        cfg_start,
  input  logic [CW-1:0]        cfg_xcnt,
  input  logic signed [MW-1:0] cfg_xmod,
  input  logic [CW-1:0]        cfg_ycnt,
  input  logic signed [MW-1:0] cfg_ymod,
  input  logic                 cfg_2d,
  input  logic                 cfg_stop,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_esize,
  input  logic                 cfg_irq_en,
  input  logic [3:0]           mv_bytes,
  output logic [AW-1:0]        cur_addr,
  output logic [CW-1:0]        cur_x,
  output logic [CW-1:0]        cur_y,
  output logic                 lat_wr,
  output logic [1:0]           lat_esize,
  output logic                 lat_stop,
  output logic                 lat_irq_en,
  output logic                 last_x,
  output logic                 more_rows,
  output logic                 cfg_misaligned,
  output logic                 rsp_zero,
  output logic                 rsp_ok
);
  import dma2d_pkg::*;

  logic signed [MW-1:0] xmod_q, ymod_q;
  logic [CW-1:0]        xcnt_q;
  logic                 two_d_q;

  function automatic logic [AW-1:0] sext(input logic signed [MW-1:0] m);
    logic signed [AW-1:0] w;
    w = AW'(m);
    return w;
  endfunction

  function automatic logic [CW-1:0] eff_count(input logic [CW-1:0] c);
    return (c == '0) ? '1 : c;
  endfunction

  function automatic logic [AW-1:0] elem_next(input logic [AW-1:0] a,
                                              input logic signed [MW-1:0] xm);
    return a + sext(xm);
  endfunction

  // Row end: undo the X stride of the last element, then apply the Y stride
  function automatic logic [AW-1:0] row_next(input logic [AW-1:0] a,
                                             input logic signed [MW-1:0] xm,
                                             input logic signed [MW-1:0] ym);
    logic [AW-1:0] post;
    post = elem_next(a, xm);
    return post - sext(xm) + sext(ym);
  endfunction

  function automatic logic misaligned(input logic [AW-1:0] a, input logic [1:0] code);
    case (code)
      2'd0:    return 1'b0;
      2'd1:    return a[0];
      default: return |a[1:0];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      cur_x      <= '0;
      cur_y      <= '0;
      xmod_q     <= '0;
      ymod_q     <= '0;
      xcnt_q     <= '0;
      two_d_q    <= 1'b0;
      lat_stop   <= 1'b0;
      lat_wr     <= 1'b0;
      lat_esize  <= 2'd0;
      lat_irq_en <= 1'b0;
    end else if (load) begin
      cur_addr   <= cfg_start;
      cur_x      <= eff_count(cfg_xcnt);
      cur_y      <= eff_count(cfg_ycnt);
      xmod_q     <= cfg_xmod;
      ymod_q     <= cfg_ymod;
      xcnt_q     <= cfg_xcnt;
      two_d_q    <= cfg_2d;
      lat_stop   <= cfg_stop;
      lat_wr     <= cfg_wr;
      lat_esize  <= cfg_esize;
      lat_irq_en <= cfg_irq_en;
    end else if (step) begin
      if (row_step) begin
        cur_addr <= row_next(cur_addr, xmod_q, ymod_q);
        cur_x    <= eff_count(xcnt_q);
        cur_y    <= cur_y - 1'b1;
      end else begin
        cur_addr <= elem_next(cur_addr, xmod_q);
        cur_x    <= cur_x - 1'b1;
      end
    end
  end

  assign last_x         = (cur_x == CW'(1));
  assign more_rows      = two_d_q && (cur_y > CW'(1));
  assign cfg_misaligned = misaligned(cfg_start, cfg_esize);
  assign rsp_zero       = (mv_bytes == 4'd0);
  assign rsp_ok         = (mv_bytes == elem_bytes(lat_esize));

  AST_ROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && row_step && !load) |=> (cur_addr == $past(cur_addr + sext(ymod_q)))); // R6

  AST_ROW_Y_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && row_step && !load) |=> (cur_y == $past(cur_y) - 1'b1)); // R6

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic en,
  input  logic desc_ack,
  input  logic cfg_misaligned,
  input  logic mv_ready,
  input  logic rsp_zero,
  input  logic rsp_ok,
  input  logic last_x,
  input  logic more_rows,
  input  logic lat_stop,
  input  logic lat_irq_en,
  input  logic timer_expired,
  output logic load,
  output logic step,
  output logic row_step,
  output logic timer_start,
  output logic mv_valid,
  output logic desc_req,
  output logic busy,
  output logic done,
  output logic err,
  output logic irq
);
  import dma2d_pkg::*;

  seq_state_e state_q, state_d, resume;
  logic accept, good, bad, stall, row_end, final_row;

  assign mv_valid  = (state_q == S_REQ);
  assign desc_req  = (state_q == S_DESC);
  assign busy      = (state_q != S_IDLE);
  assign accept    = mv_valid && mv_ready;
  assign good      = accept && rsp_ok;
  assign bad       = accept && !rsp_zero && !rsp_ok;
  assign stall     = accept && rsp_zero;
  assign row_end   = good && last_x;
  assign final_row = row_end && !more_rows;
  assign resume    = en ? S_REQ : S_ARM;

  always_comb begin
    state_d     = state_q;
    load        = 1'b0;
    step        = 1'b0;
    row_step    = 1'b0;
    timer_start = 1'b0;
    case (state_q)
      S_IDLE: if (go && !cfg_misaligned) begin
        load    = 1'b1;
        state_d = resume;
      end
      S_ARM: if (en) state_d = S_REQ;
      S_REQ: begin
        if (stall) begin
          timer_start = 1'b1;
          state_d     = S_WAIT;
        end else if (bad) begin
          state_d = S_IDLE;
        end else if (good) begin
          step     = 1'b1;
          row_step = row_end && more_rows;
          if (final_row) state_d = lat_stop ? S_IDLE : S_DESC;
          else           state_d = resume;
        end
      end
      S_WAIT: if (timer_expired) state_d = resume;
      S_DESC: if (desc_ack) begin
        if (cfg_misaligned) state_d = S_IDLE;
        else begin
          load    = 1'b1;
          state_d = resume;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done    <= 1'b0;
      err     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq     <= row_end && lat_irq_en;
      if (state_q == S_IDLE && go) begin
        done <= 1'b0;
        err  <= cfg_misaligned;
      end else begin
        if (final_row && lat_stop) done <= 1'b1;
        if (bad || (state_q == S_DESC && desc_ack && cfg_misaligned)) err <= 1'b1;
      end
    end
  end

  AST_EN_GATES_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mv_valid) |-> $past(en)); // R12

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_ack) |=> desc_req); // R9

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq #(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int MW        = 16,
  parameter int RETRY_GAP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 en,
  input  logic [AW-1:0]        cfg_start,
  input  logic [CW-1:0]        cfg_xcnt,
  input  logic signed [MW-1:0] cfg_xmod,
  input  logic [CW-1:0]        cfg_ycnt,
  input  logic signed [MW-1:0] cfg_ymod,
  input  logic                 cfg_2d,
  input  logic                 cfg_stop,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_esize,
  input  logic                 cfg_irq_en,
  output logic                 desc_req,
  input  logic                 desc_ack,
  output logic                 mv_valid,
  input  logic                 mv_ready,
  output logic [AW-1:0]        mv_addr,
  output logic                 mv_wr,
  output logic [1:0]           mv_esize,
  input  logic [3:0]           mv_bytes,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 irq,
  output logic [CW-1:0]        cur_x,
  output logic [CW-1:0]        cur_y
);
  logic load, step, row_step, timer_start, timer_expired;
  logic lat_stop, lat_irq_en, last_x, more_rows;
  logic cfg_misaligned, rsp_zero, rsp_ok;

  dma2d_datapath #(.AW(AW), .CW(CW), .MW(MW)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .row_step(row_step),
    .cfg_start(cfg_start), .cfg_xcnt(cfg_xcnt), .cfg_xmod(cfg_xmod),
    .cfg_ycnt(cfg_ycnt), .cfg_ymod(cfg_ymod), .cfg_2d(cfg_2d),
    .cfg_stop(cfg_stop), .cfg_wr(cfg_wr), .cfg_esize(cfg_esize),
    .cfg_irq_en(cfg_irq_en), .mv_bytes(mv_bytes),
    .cur_addr(mv_addr), .cur_x(cur_x), .cur_y(cur_y),
    .lat_wr(mv_wr), .lat_esize(mv_esize), .lat_stop(lat_stop),
    .lat_irq_en(lat_irq_en), .last_x(last_x), .more_rows(more_rows),
    .cfg_misaligned(cfg_misaligned), .rsp_zero(rsp_zero), .rsp_ok(rsp_ok)
  );

  dma2d_retry #(.GAP(RETRY_GAP)) u_retry (
    .clk(clk), .rst_n(rst_n), .start(timer_start), .expired(timer_expired)
  );

  dma2d_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .en(en), .desc_ack(desc_ack),
    .cfg_misaligned(cfg_misaligned), .mv_ready(mv_ready),
    .rsp_zero(rsp_zero), .rsp_ok(rsp_ok), .last_x(last_x),
    .more_rows(more_rows), .lat_stop(lat_stop), .lat_irq_en(lat_irq_en),
    .timer_expired(timer_expired), .load(load), .step(step),
    .row_step(row_step), .timer_start(timer_start), .mv_valid(mv_valid),
    .desc_req(desc_req), .busy(busy), .done(done), .err(err), .irq(irq)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_addr))); // R5

  AST_ELEM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && rsp_ok && cur_x > CW'(1)) |=> (cur_x == $past(cur_x) - 1'b1)); // R5

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && rsp_zero) |=>
      ($stable(mv_addr) && $stable(cur_x) && $stable(cur_y) && !mv_valid)); // R10

  AST_IRQ_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mv_valid && mv_ready && rsp_ok && cur_x == CW'(1))); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_ready && !rsp_zero && !rsp_ok) |=> (err && !busy && !mv_valid)); // R11

endmodule

// File: tb/dma2d_seq_tb.sv
`timescale 1ns/1ps
module dma2d_seq_tb;
  localparam int AW = 16, CW = 4, MW = 8, GAP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 0, en = 0, desc_ack = 0, mv_ready = 0;
  logic [AW-1:0] cfg_start = '0;
  logic [CW-1:0] cfg_xcnt = '0, cfg_ycnt = '0;
  logic signed [MW-1:0] cfg_xmod = '0, cfg_ymod = '0;
  logic cfg_2d = 0, cfg_stop = 1, cfg_wr = 0, cfg_irq_en = 0;
  logic [1:0] cfg_esize = '0;
  logic [3:0] mv_bytes = '0;
  logic desc_req, mv_valid, mv_wr, busy, done, err, irq;
  logic [AW-1:0] mv_addr;
  logic [1:0] mv_esize;
  logic [CW-1:0] cur_x, cur_y;

  int nchecks = 0, nerr = 0;

  always #4 clk = ~clk;

  dma2d_seq #(.AW(AW), .CW(CW), .MW(MW), .RETRY_GAP(GAP)) u_dut (
    .clk, .rst_n, .go, .en, .cfg_start, .cfg_xcnt, .cfg_xmod, .cfg_ycnt,
    .cfg_ymod, .cfg_2d, .cfg_stop, .cfg_wr, .cfg_esize, .cfg_irq_en,
    .desc_req, .desc_ack, .mv_valid, .mv_ready, .mv_addr, .mv_wr, .mv_esize,
    .mv_bytes, .busy, .done, .err, .irq, .cur_x, .cur_y
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_go();
    go = 1'b1; tick(); go = 1'b0;
  endtask

  function automatic int ebytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  // Accept every request until idle; returns elements moved
  task automatic drain(input int eb, output int n);
    n = 0;
    mv_ready = 1'b1; mv_bytes = 4'(eb);
    for (int g = 0; g < 400; g++) begin
      if (!busy || desc_req) break;
      if (mv_valid) n++;
      tick();
    end
    mv_ready = 1'b0;
  endtask

  task automatic run_case(input int st, input int x, input int y, input int xm,
                          input int ym, input bit d2, input int esz, input bit ie, input bit wr);
    int rows, total, idx, irqs, eb;
    logic [AW-1:0] expa;
    eb = ebytes(esz);
    cfg_start = AW'(st); cfg_xcnt = CW'(x); cfg_ycnt = CW'(y);
    cfg_xmod = MW'(xm); cfg_ymod = MW'(ym); cfg_2d = d2; cfg_esize = 2'(esz);
    cfg_irq_en = ie; cfg_wr = wr; cfg_stop = 1'b1; en = 1'b1;
    mv_ready = 1'b1; mv_bytes = 4'(eb);
    pulse_go();
    chk("R2", "busy after go", busy, 1);
    chk("R2", "cur_x loaded", cur_x, x);
    chk("R2", "cur_y loaded", cur_y, y);
    chk("R2", "done cleared", done, 0);
    rows = d2 ? y : 1; total = rows * x; idx = 0; irqs = 0;
    for (int g = 0; g < 200; g++) begin
      if (irq) irqs++;
      if (!busy) break;
      if (mv_valid) begin
        expa = AW'(st + (idx / x) * ((x - 1) * xm + ym) + (idx % x) * xm);
        if ((idx % x) == 0 && idx != 0) chk("R6", "row start address", mv_addr, expa);
        else                            chk("R5", "element address", mv_addr, expa);
        if (idx == 0) begin
          chk("R5", "mv_esize", mv_esize, esz);
          chk("R5", "mv_wr", mv_wr, wr);
        end
        idx++;
      end
      tick();
    end
    chk("R5", "elements moved", idx, total);
    chk("R7", "irq pulses", irqs, ie ? rows : 0);
    chk("R8", "done at end", done, 1);
    chk("R8", "no request after done", mv_valid, 0);
    tick();
    chk("R7", "irq single pulse", irq, 0);
    mv_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    int n, lowc;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "mv_valid", mv_valid, 0);
    chk("R1", "desc_req", desc_req, 0);

    // Sweep: sizes, shapes, stride signs, 1D/2D
    for (int esz = 0; esz < 3; esz++)
      for (int x = 1; x <= 3; x++)
        for (int y = 1; y <= 3; y++)
          for (int d2 = 0; d2 < 2; d2++)
            for (int sg = 0; sg < 2; sg++) begin
              int eb;
              eb = ebytes(esz);
              run_case(16'h0400 + 4 * eb, x, y, sg ? -eb : eb, sg ? 3 * eb : -2 * eb,
                       d2[0], esz, ((x + y) % 2) == 1, d2[0]);
            end

    // R3 zero counts load as maximum
    cfg_start = 16'h1000; cfg_xcnt = '0; cfg_ycnt = '0; cfg_xmod = 8'sd1;
    cfg_ymod = 8'sd1; cfg_2d = 1; cfg_esize = 0; cfg_stop = 1; cfg_irq_en = 0; en = 0;
    pulse_go();
    chk("R3", "cur_x zero->max", cur_x, 15);
    chk("R3", "cur_y zero->max", cur_y, 15);
    en = 1'b1;
    drain(1, n);
    chk("R3", "elements for max counts", n, 225);
    chk("R8", "done after max run", done, 1);

    // R4 misaligned start
    cfg_start = 16'h0102; cfg_esize = 2; cfg_xcnt = 2; cfg_2d = 0;
    pulse_go();
    chk("R4", "err word misaligned", err, 1);
    chk("R4", "busy stays low", busy, 0);
    chk("R4", "no request", mv_valid, 0);
    cfg_start = 16'h0101; cfg_esize = 1;
    pulse_go();
    chk("R4", "err half misaligned", err, 1);
    chk("R4", "busy stays low (half)", busy, 0);
    cfg_start = 16'h0100;
    pulse_go();
    chk("R2", "err cleared by aligned go", err, 0);
    drain(2, n);
    chk("R2", "aligned run length", n, 2);

    // R13 go and cfg ignored while busy; R5 hold under back-pressure
    cfg_start = 16'h0200; cfg_xcnt = 3; cfg_ycnt = 1; cfg_esize = 1; cfg_xmod = 8'sd2;
    cfg_stop = 1; en = 1; mv_ready = 0;
    pulse_go();
    chk("R5", "valid issued", mv_valid, 1);
    tick(); tick();
    chk("R5", "valid held", mv_valid, 1);
    chk("R5", "addr held", mv_addr, 16'h0200);
    cfg_start = 16'h0300; cfg_xcnt = 5; cfg_esize = 0;
    pulse_go();
    chk("R13", "addr unchanged by go", mv_addr, 16'h0200);
    chk("R13", "cur_x unchanged by go", cur_x, 3);
    chk("R13", "esize unchanged", mv_esize, 1);
    drain(2, n);
    chk("R13", "old element count kept", n, 3);

    // R10 stall and retry gap
    cfg_start = 16'h0500; cfg_xcnt = 2; cfg_esize = 1; cfg_xmod = 8'sd2; en = 1;
    mv_ready = 1; mv_bytes = 0;
    pulse_go();
    chk("R10", "valid before stall", mv_valid, 1);
    tick();
    chk("R10", "valid low after stall", mv_valid, 0);
    chk("R10", "addr unchanged", mv_addr, 16'h0500);
    chk("R10", "cur_x unchanged", cur_x, 2);
    mv_bytes = 4'd2;
    lowc = 1;
    for (int g = 0; g < 50; g++) begin
      tick();
      if (mv_valid) break;
      lowc++;
    end
    chk("R10", "retry gap cycles", lowc, GAP);
    chk("R10", "addr on retry", mv_addr, 16'h0500);
    drain(2, n);
    chk("R10", "elements after stall", n, 2);

    // R11 bad byte count
    cfg_start = 16'h0600; cfg_xcnt = 3; cfg_esize = 2; cfg_xmod = 8'sd4;
    mv_ready = 1; mv_bytes = 4'd3;
    pulse_go();
    tick();
    chk("R11", "err set", err, 1);
    chk("R11", "busy cleared", busy, 0);
    chk("R11", "element not counted", cur_x, 3);
    tick(); tick(); tick();
    chk("R11", "no further request", mv_valid, 0);
    mv_ready = 0;

    // R12 enable gating
    cfg_start = 16'h0700; cfg_xcnt = 3; cfg_esize = 0; cfg_xmod = 8'sd1;
    en = 0; mv_ready = 1; mv_bytes = 1;
    pulse_go();
    chk("R12", "busy while disabled", busy, 1);
    chk("R12", "no request while disabled", mv_valid, 0);
    tick(); tick(); tick();
    chk("R12", "still no request", mv_valid, 0);
    chk("R12", "cur_x idle", cur_x, 3);
    en = 1;
    tick();
    chk("R12", "request after enable", mv_valid, 1);
    chk("R12", "first address", mv_addr, 16'h0700);
    en = 0;
    tick();
    chk("R12", "inflight completed", cur_x, 2);
    chk("R12", "stopped at boundary", mv_valid, 0);
    chk("R12", "addr advanced once", mv_addr, 16'h0701);
    tick(); tick(); tick();
    chk("R12", "held while disabled", cur_x, 2);
    en = 1;
    drain(1, n);
    chk("R12", "remaining elements", n, 2);

    // R9 descriptor chaining
    cfg_start = 16'h0800; cfg_xcnt = 2; cfg_ycnt = 1; cfg_2d = 0; cfg_esize = 0;
    cfg_xmod = 8'sd1; cfg_stop = 0; en = 1; mv_ready = 1; mv_bytes = 1;
    pulse_go();
    tick(); tick();
    chk("R9", "desc_req raised", desc_req, 1);
    chk("R9", "busy kept", busy, 1);
    chk("R9", "no request while fetching", mv_valid, 0);
    chk("R9", "done not set", done, 0);
    tick();
    chk("R9", "desc_req held", desc_req, 1);
    cfg_start = 16'h0900; cfg_xcnt = 3; cfg_stop = 1; desc_ack = 1;
    tick();
    desc_ack = 0;
    chk("R9", "desc_req dropped", desc_req, 0);
    chk("R9", "new address", mv_addr, 16'h0900);
    chk("R9", "new cur_x", cur_x, 3);
    chk("R9", "resumed", mv_valid, 1);
    drain(1, n);
    chk("R9", "chained elements", n, 3);
    chk("R9", "done after chain", done, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule